// File: doc/BRIEF.md
# Arbitrating Address-Phase Transmitter

This block is the address-phase engine of a master on a shared serial bus where every node drives through a wired-AND, so a 0 on the line always wins over a 1. It works on abstract bit slots. A bit strobe marks each slot. The block presents the bit it wants on the line, and it reads back the value that the line actually carried. Generating the line waveform is left to other logic.

Once it accepts a request, the block sends its own 12-bit address MSB first, followed by an even-parity bit. It checks every address bit against the line. If the line shows a different value, the block has lost arbitration: it stops driving and goes back to idle, where it only listens. When several masters contend this way, the one with the numerically lowest address keeps the bus. A winner goes on to send the 12-bit target address and that address's parity bit. For a directed transfer it then releases the line for one acknowledge slot. For a broadcast it moves straight to the control phase.

The request is a valid/ready handshake. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. A requester that sees `req_ready` low must hold its request until ready returns. While a transfer is running, anything on the request pins is ignored. All outcome indications are single-cycle pulses.

Top module: `arbtx_master`

## Requirements
- R1: `req_ready` is 1 exactly when idle. A request is taken only on an edge with `req_valid` and `req_ready` both high. While busy, `req_valid` and the request fields have no effect on the bits sent.
- R2: After acceptance, the 12 own-address bits appear on `tx_bit` MSB first, one per slot. `tx_bit` changes only on the clock edge that samples a `bit_stb`, or on the edge that accepts a request.
- R3: In an own-address slot, if `bus_bit` differs from the driven bit (in either direction), `lost` pulses for one cycle after that strobe edge. From that edge on, `tx_bit` is 1 and `req_ready` is 1.
- R4: The slot after the 12 own-address bits carries a parity bit. It is 1 when the own address holds an odd number of ones.
- R5: Next come the 12 target-address bits, MSB first, followed by their parity bit (1 when the count of ones is odd).
- R6: For a directed transfer (`req_bcast`=0), one more slot follows with `tx_bit`=1. A `bus_bit` of 0 there pulses `acked` and `go_ctrl` together. A `bus_bit` of 1 pulses `nacked` only. Either way the block then goes idle.
- R7: For a broadcast (`req_bcast`=1), `go_ctrl` pulses right after the target parity slot. No acknowledge slot follows, and `acked` and `nacked` stay 0.
- R8: After reset and whenever idle, `tx_bit` is 1, `req_ready` is 1, and all outcome pulses are 0.
- R9: At most one of `lost`, `nacked` and `go_ctrl` pulses in any cycle, and `acked` never pulses without `go_ctrl`.
- R10: When two masters contend over a wired-AND line, the one with the lower address completes the address phase and the higher one reports `lost`.
- R11: A mismatch between `bus_bit` and `tx_bit` in a parity slot or a target-address slot is not arbitration. The transfer continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle and able to take a request |
| req_own | input | 12 | Own (master) address |
| req_dest | input | 12 | Target (slave) address |
| req_bcast | input | 1 | 1 = broadcast transfer |
| bit_stb | input | 1 | One-cycle strobe marking a bit slot |
| bus_bit | input | 1 | Line value sampled for the current slot |
| tx_bit | output | 1 | Bit to drive; 1 is recessive |
| lost | output | 1 | Pulse: arbitration lost |
| acked | output | 1 | Pulse: acknowledge seen |
| nacked | output | 1 | Pulse: no acknowledge |
| go_ctrl | output | 1 | Pulse: proceed to control field |

## Verification
If the slot counter or phase register goes wrong, the fault shows up at the very next strobe. Either `tx_bit` carries a bit from the wrong field, or an outcome pulse appears one slot early or late. Checking every slot against a frame built independently exposes this within one slot. A bad compare path shows up in the same strobe cycle: `lost` is missing or spurious, and `req_ready` does not return. A parity fault is confined to two slots per transfer, and each of those slots is checked.

// File: rtl/arbtx_pkg.sv
package arbtx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_OWN   = 3'd1,
    PH_OWNP  = 3'd2,
    PH_DST   = 3'd3,
    PH_DSTP  = 3'd4,
    PH_ACK   = 3'd5
  } phase_t;

  typedef struct packed {
    logic lost;
    logic nack;
    logic ack;
    logic go;
  } outcome_t;
endpackage

// File: rtl/arbtx_parity.sv
module arbtx_parity #(
  parameter int W = 12
) (
  input  logic [W-1:0] vec,
  output logic         odd
);
  logic [W:0] chain;
  assign chain[0] = 1'b0;
  for (genvar g = 0; g < W; g++) begin : g_xor
    assign chain[g+1] = chain[g] ^ vec[g];
  end
  assign odd = chain[W];
endmodule

// File: rtl/arbtx_frame.sv
module arbtx_frame #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] own,
  input  logic [W-1:0] dest,
  output logic         cur_bit
);
  localparam int FW = 2 * W + 2;

  logic          own_odd, dest_odd;
  logic [FW-1:0] frame_q;

  arbtx_parity #(.W(W)) u_own_par  (.vec(own),  .odd(own_odd));
  arbtx_parity #(.W(W)) u_dest_par (.vec(dest), .odd(dest_odd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
    end else if (load) begin
      frame_q <= {own, own_odd, dest, dest_odd};
    end else if (shift) begin
      frame_q <= {frame_q[FW-2:0], 1'b1};
    end
  end

  assign cur_bit = frame_q[FW-1];
endmodule

// File: rtl/arbtx_seq.sv
module arbtx_seq
  import arbtx_pkg::*;
#(
  parameter int W = 12
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     accept,
  input  logic     bcast_in,
  input  logic     bit_stb,
  input  logic     bus_bit,
  input  logic     cur_bit,
  output phase_t   phase,
  output logic     shift,
  output outcome_t res
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  phase_t        phase_q;
  logic [CW-1:0] cnt_q;
  logic          bc_q;
  outcome_t      res_q;
  logic          mismatch;

  assign mismatch = bus_bit != cur_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      bc_q    <= 1'b0;
      res_q   <= '0;
    end else begin
      res_q <= '0;
      if (phase_q == PH_IDLE) begin
        if (accept) begin
          phase_q <= PH_OWN;
          cnt_q   <= LAST;
          bc_q    <= bcast_in;
        end
      end else if (bit_stb) begin
        unique case (phase_q)
          PH_OWN: begin
            if (mismatch) begin
              res_q.lost <= 1'b1;
              phase_q    <= PH_IDLE;
            end else if (cnt_q == '0) begin
              phase_q <= PH_OWNP;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          PH_OWNP: begin
            phase_q <= PH_DST;
            cnt_q   <= LAST;
          end
          PH_DST: begin
            if (cnt_q == '0) phase_q <= PH_DSTP;
            else             cnt_q   <= cnt_q - 1'b1;
          end
          PH_DSTP: begin
            if (bc_q) begin
              res_q.go <= 1'b1;
              phase_q  <= PH_IDLE;
            end else begin
              phase_q <= PH_ACK;
            end
          end
          PH_ACK: begin
            if (!bus_bit) begin
              res_q.ack <= 1'b1;
              res_q.go  <= 1'b1;
            end else begin
              res_q.nack <= 1'b1;
            end
            phase_q <= PH_IDLE;
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign shift = bit_stb && (phase_q inside {PH_OWN, PH_OWNP, PH_DST, PH_DSTP})
                 && !(phase_q == PH_OWN && mismatch);
  assign phase = phase_q;
  assign res   = res_q;

  // R9: outcomes exclusive; ack always with go
  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_q.lost, res_q.nack, res_q.go}));
  p_ack_with_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_q.ack |-> res_q.go);
  // R11: loss only arises from an own-address slot
  p_lost_from_own_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_q.lost |-> $past(phase_q) == PH_OWN);
  // R7: a broadcast never reports missing acknowledge
  p_bcast_no_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_q.nack |-> !bc_q);
  // R6: acknowledge result only from the ack slot
  p_ack_from_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q.ack || res_q.nack) |-> $past(phase_q) == PH_ACK);
endmodule

// File: rtl/arbtx_master.sv
module arbtx_master
  import arbtx_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] req_own,
  input  logic [W-1:0] req_dest,
  input  logic         req_bcast,
  input  logic         bit_stb,
  input  logic         bus_bit,
  output logic         tx_bit,
  output logic         lost,
  output logic         acked,
  output logic         nacked,
  output logic         go_ctrl
);
  phase_t   phase;
  outcome_t res;
  logic     accept, shift, cur_bit, driving;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;

  arbtx_frame #(.W(W)) u_frame (
    .clk(clk), .rst_n(rst_n), .load(accept), .shift(shift),
    .own(req_own), .dest(req_dest), .cur_bit(cur_bit)
  );

  arbtx_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .bcast_in(req_bcast),
    .bit_stb(bit_stb), .bus_bit(bus_bit), .cur_bit(cur_bit),
    .phase(phase), .shift(shift), .res(res)
  );

  assign driving = phase inside {PH_OWN, PH_OWNP, PH_DST, PH_DSTP};
  assign tx_bit  = driving ? cur_bit : 1'b1;
  assign lost    = res.lost;
  assign acked   = res.ack;
  assign nacked  = res.nack;
  assign go_ctrl = res.go;

  // R1: an accepted request leaves idle on the next edge
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R8: idle means recessive
  p_idle_recessive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> tx_bit);
  // R3: after loss the line is released and the block is idle
  p_lost_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> (tx_bit && req_ready));
  // R2: driven bit holds between slots
  p_tx_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready) && !$past(bit_stb)) |-> $stable(tx_bit));
endmodule

// File: tb/arbtx_master_test.sv
module arbtx_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_bcast = 1'b0, bit_stb = 1'b0, bus_bit = 1'b1;
  logic [W-1:0] req_own = '0, req_dest = '0;
  logic req_ready, tx_bit, lost, acked, nacked, go_ctrl;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  int exp_q[$];
  string tag_q[$];

  arbtx_master #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_own(req_own), .req_dest(req_dest), .req_bcast(req_bcast),
    .bit_stb(bit_stb), .bus_bit(bus_bit), .tx_bit(tx_bit), .lost(lost),
    .acked(acked), .nacked(nacked), .go_ctrl(go_ctrl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic odd12(input logic [W-1:0] v);
    logic p = 1'b0;
    for (int i = 0; i < W; i++) p ^= v[i];
    return p;
  endfunction

  // outcome codes: 0 lost, 1 nack, 2 ack+go, 3 go only
  always @(negedge clk) begin
    if (rst_n && (lost || acked || nacked || go_ctrl)) begin
      int code;
      if (lost) code = 0;
      else if (nacked) code = 1;
      else if (acked && go_ctrl) code = 2;
      else if (go_ctrl) code = 3;
      else code = 4;
      if (exp_q.size() == 0) check("R9 unexpected outcome", code, -1);
      else check(tag_q.pop_front(), code, exp_q.pop_front());
    end
  end

  task automatic xfer(input logic [W-1:0] own, input logic [W-1:0] dest,
                      input logic bc, input logic cont_on, input logic [W-1:0] cont,
                      input logic ack_resp, input int force_k, input string tag);
    logic [2*W+2:0] frm;
    int nslots, lose_at;
    frm = {own, odd12(own), dest, odd12(dest), 1'b1};
    nslots = bc ? 2*W+2 : 2*W+3;
    lose_at = -1;
    for (int k = 0; k < W; k++) begin
      logic d, b;
      d = own[W-1-k];
      b = d & (cont_on ? cont[W-1-k] : 1'b1);
      if (k == force_k) b = ~b;
      if (b != d && lose_at < 0) lose_at = k;
    end
    exp_q.push_back(lose_at >= 0 ? 0 : (bc ? 3 : (ack_resp ? 2 : 1)));
    tag_q.push_back(tag);
    @(negedge clk);
    check("R1 ready before request", req_ready, 1);
    req_valid = 1'b1; req_own = own; req_dest = dest; req_bcast = bc;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < nslots; k++) begin
      logic d, b;
      for (int g = 0; g < (k % 3) + 1; g++) begin
        if (k == 2 && g == 0) begin
          // R1: request while busy is ignored
          req_valid = 1'b1; req_own = ~own; req_dest = ~dest; req_bcast = ~bc;
          check("R1 ready low while busy", req_ready, 0);
        end else req_valid = 1'b0;
        @(negedge clk);
      end
      req_valid = 1'b0;
      d = frm[2*W+2-k];
      check(k < W ? "R2 own bit" : k == W ? "R4 own parity" :
            k < 2*W+2 ? "R5 target bit" : "R6 ack slot recessive", tx_bit, d);
      b = d;
      if (k < W && cont_on) b = d & cont[W-1-k];
      if (k == force_k) b = ~b; // R11 when forced outside own address
      if (k == 2*W+2) b = ack_resp ? 1'b0 : 1'b1;
      bit_stb = 1'b1; bus_bit = b;
      @(negedge clk);
      bit_stb = 1'b0; bus_bit = 1'b1;
      if (k == lose_at) begin
        check("R3 released after loss", tx_bit, 1);
        check("R3 ready after loss", req_ready, 1);
        break;
      end
    end
    @(negedge clk); @(negedge clk);
    check("R8 idle recessive", tx_bit, 1);
    check("R8 idle ready", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset ready", req_ready, 1);
    check("R8 reset tx", tx_bit, 1);
    check("R8 reset outcomes", {lost, acked, nacked, go_ctrl}, 0);
    rst_n = 1'b1;
    xfer(12'hA5C, 12'h123, 1'b0, 1'b0, '0, 1'b1, -1, "R6 ack seen");
    xfer(12'h7F1, 12'h80E, 1'b0, 1'b0, '0, 1'b0, -1, "R6 no ack");
    xfer(12'h001, 12'hFFF, 1'b1, 1'b0, '0, 1'b0, -1, "R7 broadcast");
    xfer(12'h3C4, 12'h5A5, 1'b0, 1'b1, 12'h3C0, 1'b1, -1, "R10 higher address loses");
    xfer(12'h3C0, 12'h5A5, 1'b0, 1'b1, 12'h3C4, 1'b1, -1, "R10 lower address wins");
    xfer(12'h800, 12'h010, 1'b0, 1'b1, 12'h7FF, 1'b1, -1, "R3 loss at MSB");
    xfer(12'h000, 12'h010, 1'b0, 1'b0, '0, 1'b1, 5, "R3 loss on read-back 1");
    xfer(12'h246, 12'h9BD, 1'b0, 1'b0, '0, 1'b1, 15, "R11 target mismatch ignored");
    xfer(12'h246, 12'h9BD, 1'b1, 1'b0, '0, 1'b0, 12, "R11 parity mismatch ignored");
    xfer(12'hFFF, 12'hE00, 1'b1, 1'b1, 12'hFFF, 1'b0, -1, "R7 equal contender broadcast");
    check("R9 all outcomes seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule